// File: doc/BRIEF.md
# Flash Identification Table Read Port

This block answers reads from the self-description table of a NOR flash model. A flash that is in its identification mode returns, on the low byte lane, one byte of a fixed structure that tells a driver the device's signature, vendor command-set codes, supply and timing figures, size, bus interface and erase layout. The structure has a constant-length header. A list of 4-byte erase-region descriptors follows it, one descriptor for each region. Every byte comes from parameters set when the block is built.

The surrounding command logic drives `query_mode` and a word address that has already been scaled to the bus width. The table answers an enabled read whose address lies inside the table window while query mode is on. Any other read passes through the data offered on the secondary read input, such as array contents or status. Results appear one clock after the request, with a flag that tells whether the table answered.

Top module: `qtab_read_port`

## Requirements
- R1: While reset is asserted and on the first clock after its release with no read, `rd_valid`, `rd_hit` and `rd_data` are all zero.
- R2: A read requested with `rd_en` in one cycle is answered with `rd_valid` high on the next clock edge only. `rd_valid` is low after any cycle without `rd_en`.
- R3: With query mode on, word addresses BASE_ADDR, BASE_ADDR+1 and BASE_ADDR+2 return 0x51, 0x52 and 0x59 ("Q", "R", "Y"). BASE_ADDR defaults to 0x10.
- R4: Offsets 3 to 27 from BASE_ADDR return the remaining header fields, with multi-byte fields low byte first. The primary vendor code is at 3-4 and the primary table address at 5-6. The alternate vendor code is at 7-8 and the alternate table address at 9-10. The four voltage bytes are at 11-14, with byte n taken from VOLTAGES bits 8n+7:8n. The eight timeout bytes are at 15-22, taken from TIMEOUTS in the same way. The log2 device size is at 23, the interface code at 24-25 and the log2 maximum buffer length at 26-27.
- R5: Offset 28 returns NUM_REGIONS, the number of erase regions (0 to 4).
- R6: Region i's descriptor sits at offsets 29+4i to 32+4i. Its first two bytes hold (block count − 1) low byte first. Its last two bytes hold (block size in bytes ÷ 256) low byte first.
- R7: On a table hit, every bit of `rd_data` above bit 7 is zero.
- R8: A read whose address is below BASE_ADDR, or at or above BASE_ADDR+29+4×NUM_REGIONS, returns the value `alt_data` had in the request cycle, with `rd_hit` low. A read inside that window in query mode returns table data with `rd_hit` high.
- R9: With `query_mode` low, every read returns `alt_data` with `rd_hit` low, including reads at addresses inside the table window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| query_mode | input | 1 | Table answers reads when high |
| rd_en | input | 1 | Read request, one cycle per read |
| rd_addr | input | ADDR_W | Word address, already scaled to bus width |
| alt_data | input | BUS_W | Secondary read data used when the table does not answer |
| rd_data | output | BUS_W | Read result, registered |
| rd_valid | output | 1 | High one cycle after `rd_en` |
| rd_hit | output | 1 | Result came from the table |

## Verification
The bench reads every table byte and compares it with a structure it builds itself from the field list. A design with a field out of place, or with its bytes in the wrong order, fails at that offset. The window edges are the main targets. BASE_ADDR−1 and the first address past the last descriptor must pass `alt_data` through, and a design with an off-by-one end bound would instead return a region byte or zero. The last descriptor byte must still come from the table. A read at the signature address with query mode off must return the secondary data, so a design that ignores the mode returns "Q" there. A secondary value with its high lanes set shows whether table bytes leak data into the upper lanes or fail to clear them.

// File: rtl/qtab_pkg.sv
package qtab_pkg;

  // bytes in the fixed part of the table
  localparam int unsigned QT_HDR_LEN = 29;
  // upper bound on erase regions the table can describe
  localparam int unsigned QT_MAX_REGIONS = 4;
  // bytes in one region descriptor
  localparam int unsigned QT_DESC_LEN = 4;

  localparam logic [7:0] QT_SIG0 = 8'h51;
  localparam logic [7:0] QT_SIG1 = 8'h52;
  localparam logic [7:0] QT_SIG2 = 8'h59;

  // descriptor word: low half = blocks-1, high half = size/256;
  // byte 0 of the descriptor is bits 7:0
  function automatic logic [31:0] qt_desc_word(input logic [31:0] blocks,
                                               input logic [31:0] bytes);
    logic [31:0] cnt_m1;
    logic [31:0] units;
    cnt_m1 = blocks - 32'd1;
    units  = bytes >> 8;
    return {units[15:0], cnt_m1[15:0]};
  endfunction

  // first address past the table
  function automatic int unsigned qt_window_end(input int unsigned base,
                                                input int unsigned nreg);
    return base + QT_HDR_LEN + QT_DESC_LEN * nreg;
  endfunction

endpackage

// File: rtl/qtab_window.sv
module qtab_window
  import qtab_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned BASE_ADDR   = 16,
  parameter int unsigned NUM_REGIONS = 2,
  localparam int unsigned HI_W = $clog2(QT_HDR_LEN),
  localparam int unsigned RI_W = $clog2(QT_DESC_LEN * QT_MAX_REGIONS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              query_mode,
  input  logic [ADDR_W-1:0] addr,
  output logic              in_hdr,
  output logic              in_reg,
  output logic [HI_W-1:0]   hdr_idx,
  output logic [RI_W-1:0]   reg_idx
);

  localparam int unsigned END_ADDR = qt_window_end(BASE_ADDR, NUM_REGIONS);
  localparam int unsigned HDR_END  = BASE_ADDR + QT_HDR_LEN;

  logic [31:0] addr_w;
  logic [31:0] off_hdr;
  logic [31:0] off_reg;

  assign addr_w  = 32'(addr);
  assign off_hdr = addr_w - BASE_ADDR;
  assign off_reg = off_hdr - QT_HDR_LEN;

  assign in_hdr  = query_mode && (addr_w >= BASE_ADDR) && (addr_w < HDR_END);
  assign in_reg  = query_mode && (addr_w >= HDR_END) && (addr_w < END_ADDR);
  assign hdr_idx = off_hdr[HI_W-1:0];
  assign reg_idx = off_reg[RI_W-1:0];

  // R8
  window_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_hdr && in_reg));

  // R9
  window_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !query_mode |-> !(in_hdr || in_reg));

endmodule

// File: rtl/qtab_header_rom.sv
module qtab_header_rom
  import qtab_pkg::*;
#(
  parameter logic [15:0] PRI_ID      = 16'h0A03,
  parameter logic [15:0] PRI_ADR     = 16'h0031,
  parameter logic [15:0] ALT_ID      = 16'h0C02,
  parameter logic [15:0] ALT_ADR     = 16'h0042,
  parameter logic [31:0] VOLTAGES    = 32'h9B12_3627,
  parameter logic [63:0] TIMEOUTS    = 64'h0F0A_0908_0403_0201,
  parameter logic [7:0]  DEV_LOG2    = 8'h16,
  parameter logic [15:0] IFACE       = 16'h0002,
  parameter logic [15:0] BUF_LOG2    = 16'h0006,
  parameter int unsigned NUM_REGIONS = 2,
  localparam int unsigned HI_W = $clog2(QT_HDR_LEN)
) (
  input  logic [HI_W-1:0] idx,
  output logic [7:0]      byte_out
);

  localparam int unsigned PAD_BITS = (2 ** HI_W) * 8;

  // byte 0 of the table sits in bits 7:0
  localparam logic [QT_HDR_LEN*8-1:0] HDR = {
    8'(NUM_REGIONS), BUF_LOG2, IFACE, DEV_LOG2, TIMEOUTS, VOLTAGES,
    ALT_ADR, ALT_ID, PRI_ADR, PRI_ID, QT_SIG2, QT_SIG1, QT_SIG0
  };

  localparam logic [PAD_BITS-1:0] HDR_PAD = PAD_BITS'(HDR);

  assign byte_out = HDR_PAD[{idx, 3'b000} +: 8];

endmodule

// File: rtl/qtab_region_rom.sv
module qtab_region_rom
  import qtab_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 2,
  parameter logic [32*QT_MAX_REGIONS-1:0] REGION_BLOCKS =
    {32'd0, 32'd0, 32'd63, 32'd8},
  parameter logic [32*QT_MAX_REGIONS-1:0] REGION_BYTES =
    {32'd0, 32'd0, 32'd65536, 32'd8192},
  localparam int unsigned RI_W = $clog2(QT_DESC_LEN * QT_MAX_REGIONS)
) (
  input  logic [RI_W-1:0] idx,
  output logic [7:0]      byte_out
);

  logic [QT_MAX_REGIONS-1:0][31:0] desc;

  for (genvar g = 0; g < QT_MAX_REGIONS; g++) begin : g_desc
    if (g < NUM_REGIONS) begin : g_used
      assign desc[g] = qt_desc_word(REGION_BLOCKS[32*g +: 32],
                                    REGION_BYTES[32*g +: 32]);
    end else begin : g_unused
      assign desc[g] = 32'd0;
    end
  end

  logic [31:0] sel_word;
  assign sel_word = desc[idx[RI_W-1:2]];
  assign byte_out = sel_word[{idx[1:0], 3'b000} +: 8];

endmodule

// File: rtl/qtab_read_port.sv
module qtab_read_port
  import qtab_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned BUS_W       = 16,
  parameter int unsigned BASE_ADDR   = 16,
  parameter logic [15:0] PRI_ID      = 16'h0A03,
  parameter logic [15:0] PRI_ADR     = 16'h0031,
  parameter logic [15:0] ALT_ID      = 16'h0C02,
  parameter logic [15:0] ALT_ADR     = 16'h0042,
  parameter logic [31:0] VOLTAGES    = 32'h9B12_3627,
  parameter logic [63:0] TIMEOUTS    = 64'h0F0A_0908_0403_0201,
  parameter logic [7:0]  DEV_LOG2    = 8'h16,
  parameter logic [15:0] IFACE       = 16'h0002,
  parameter logic [15:0] BUF_LOG2    = 16'h0006,
  parameter int unsigned NUM_REGIONS = 2,
  parameter logic [32*QT_MAX_REGIONS-1:0] REGION_BLOCKS =
    {32'd0, 32'd0, 32'd63, 32'd8},
  parameter logic [32*QT_MAX_REGIONS-1:0] REGION_BYTES =
    {32'd0, 32'd0, 32'd65536, 32'd8192}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              query_mode,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [BUS_W-1:0]  alt_data,
  output logic [BUS_W-1:0]  rd_data,
  output logic              rd_valid,
  output logic              rd_hit
);

  localparam int unsigned HI_W     = $clog2(QT_HDR_LEN);
  localparam int unsigned RI_W     = $clog2(QT_DESC_LEN * QT_MAX_REGIONS);
  localparam int unsigned END_ADDR = qt_window_end(BASE_ADDR, NUM_REGIONS);

  logic            in_hdr;
  logic            in_reg;
  logic [HI_W-1:0] hdr_idx;
  logic [RI_W-1:0] reg_idx;
  logic [7:0]      hdr_byte;
  logic [7:0]      reg_byte;
  logic            table_hit;
  logic [7:0]      table_byte;

  qtab_window #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_REGIONS(NUM_REGIONS)
  ) u_window (
    .clk(clk), .rst_n(rst_n), .query_mode(query_mode), .addr(rd_addr),
    .in_hdr(in_hdr), .in_reg(in_reg), .hdr_idx(hdr_idx), .reg_idx(reg_idx)
  );

  qtab_header_rom #(
    .PRI_ID(PRI_ID), .PRI_ADR(PRI_ADR), .ALT_ID(ALT_ID), .ALT_ADR(ALT_ADR),
    .VOLTAGES(VOLTAGES), .TIMEOUTS(TIMEOUTS), .DEV_LOG2(DEV_LOG2),
    .IFACE(IFACE), .BUF_LOG2(BUF_LOG2), .NUM_REGIONS(NUM_REGIONS)
  ) u_header (
    .idx(hdr_idx), .byte_out(hdr_byte)
  );

  qtab_region_rom #(
    .NUM_REGIONS(NUM_REGIONS), .REGION_BLOCKS(REGION_BLOCKS),
    .REGION_BYTES(REGION_BYTES)
  ) u_region (
    .idx(reg_idx), .byte_out(reg_byte)
  );

  assign table_hit  = in_hdr || in_reg;
  assign table_byte = in_hdr ? hdr_byte : reg_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      rd_hit   <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_hit   <= rd_en && table_hit;
      if (rd_en) begin
        rd_data <= table_hit ? BUS_W'(table_byte) : alt_data;
      end
    end
  end

  // R7
  upper_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (rd_data >> 8) == '0);

  // R3
  signature_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && query_mode && (32'(rd_addr) == BASE_ADDR) |=>
      rd_hit && rd_data[7:0] == QT_SIG0);

  // R8
  below_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (32'(rd_addr) < BASE_ADDR) |=>
      !rd_hit && rd_data == $past(alt_data));

  // R8
  above_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (32'(rd_addr) >= END_ADDR) |=>
      !rd_hit && rd_data == $past(alt_data));

  // R9
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !query_mode |=> !rd_hit && rd_data == $past(alt_data));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid && !rd_hit);

endmodule

// File: tb/qtab_read_port_test.sv
module qtab_read_port_test;

  localparam int CLK_PERIOD = 10;
  localparam int BASE = 16;
  localparam int NREG = 2;
  localparam int TLEN = 29 + 4 * NREG;

  localparam logic [15:0] T_PRI_ID  = 16'h0A03;
  localparam logic [15:0] T_PRI_ADR = 16'h0031;
  localparam logic [15:0] T_ALT_ID  = 16'h0C02;
  localparam logic [15:0] T_ALT_ADR = 16'h0042;
  localparam logic [31:0] T_VOLT    = 32'h9B12_3627;
  localparam logic [63:0] T_TMO     = 64'h0F0A_0908_0403_0201;
  localparam logic [7:0]  T_DEV     = 8'h16;
  localparam logic [15:0] T_IFACE   = 16'h0002;
  localparam logic [15:0] T_BUF     = 16'h0006;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        query_mode = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [15:0] alt_data = '0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        rd_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model [0:TLEN-1];

  always #(CLK_PERIOD / 2) clk = ~clk;

  qtab_read_port #(
    .ADDR_W(16), .BUS_W(16), .BASE_ADDR(BASE),
    .PRI_ID(T_PRI_ID), .PRI_ADR(T_PRI_ADR), .ALT_ID(T_ALT_ID),
    .ALT_ADR(T_ALT_ADR), .VOLTAGES(T_VOLT), .TIMEOUTS(T_TMO),
    .DEV_LOG2(T_DEV), .IFACE(T_IFACE), .BUF_LOG2(T_BUF),
    .NUM_REGIONS(NREG),
    .REGION_BLOCKS({32'd0, 32'd0, 32'd63, 32'd8}),
    .REGION_BYTES({32'd0, 32'd0, 32'd65536, 32'd8192})
  ) uut (
    .clk(clk), .rst_n(rst_n), .query_mode(query_mode), .rd_en(rd_en),
    .rd_addr(rd_addr), .alt_data(alt_data), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_hit(rd_hit)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic build_model();
    model[0] = 8'h51; model[1] = 8'h52; model[2] = 8'h59;
    model[3] = T_PRI_ID[7:0];   model[4] = T_PRI_ID[15:8];
    model[5] = T_PRI_ADR[7:0];  model[6] = T_PRI_ADR[15:8];
    model[7] = T_ALT_ID[7:0];   model[8] = T_ALT_ID[15:8];
    model[9] = T_ALT_ADR[7:0];  model[10] = T_ALT_ADR[15:8];
    for (int n = 0; n < 4; n++) model[11 + n] = T_VOLT[8*n +: 8];
    for (int n = 0; n < 8; n++) model[15 + n] = T_TMO[8*n +: 8];
    model[23] = T_DEV;
    model[24] = T_IFACE[7:0]; model[25] = T_IFACE[15:8];
    model[26] = T_BUF[7:0];   model[27] = T_BUF[15:8];
    model[28] = 8'(NREG);
    // region 0: 8 blocks of 8 KiB -> 7, 32
    model[29] = 8'h07; model[30] = 8'h00; model[31] = 8'h20; model[32] = 8'h00;
    // region 1: 63 blocks of 64 KiB -> 62, 256
    model[33] = 8'h3E; model[34] = 8'h00; model[35] = 8'h00; model[36] = 8'h01;
  endtask

  // one read; results are sampled at the falling edge after the capture edge
  task automatic do_read(input logic [15:0] a, input logic mode,
                         input logic [15:0] alt);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a; query_mode = mode; alt_data = alt;
    @(negedge clk);
    rd_en = 1'b0; alt_data = 16'h0000;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(rd_valid), 0);
    chk("R1 hit in reset", 32'(rd_hit), 0);
    chk("R1 data in reset", 32'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", 32'(rd_valid), 0);
    chk("R1 data after release", 32'(rd_data), 0);
  endtask

  task automatic t_signature();
    do_read(16'(BASE), 1'b1, 16'hFFFF);
    chk("R3 Q", 32'(rd_data), 32'h51);
    chk("R2 valid", 32'(rd_valid), 1);
    chk("R8 hit", 32'(rd_hit), 1);
    @(negedge clk);
    chk("R2 valid drops", 32'(rd_valid), 0);
    do_read(16'(BASE + 1), 1'b1, 16'hFFFF);
    chk("R3 R", 32'(rd_data), 32'h52);
    do_read(16'(BASE + 2), 1'b1, 16'hFFFF);
    chk("R3 Y", 32'(rd_data), 32'h59);
  endtask

  task automatic t_header();
    for (int k = 3; k < 28; k++) begin
      do_read(16'(BASE + k), 1'b1, 16'hFF00);
      chk($sformatf("R4 offset %0d", k), 32'(rd_data), 32'(model[k]));
    end
    do_read(16'(BASE + 28), 1'b1, 16'hFF00);
    chk("R5 region count", 32'(rd_data), 32'(model[28]));
  endtask

  task automatic t_regions();
    for (int k = 29; k < TLEN; k++) begin
      do_read(16'(BASE + k), 1'b1, 16'hFF00);
      chk($sformatf("R6 offset %0d", k), 32'(rd_data), 32'(model[k]));
      chk($sformatf("R7 upper lanes offset %0d", k), 32'(rd_data[15:8]), 0);
    end
  endtask

  task automatic t_edges();
    do_read(16'(BASE - 1), 1'b1, 16'hA5C3);
    chk("R8 below base data", 32'(rd_data), 32'hA5C3);
    chk("R8 below base hit", 32'(rd_hit), 0);
    do_read(16'(BASE + TLEN - 1), 1'b1, 16'hA5C3);
    chk("R8 last byte hit", 32'(rd_hit), 1);
    chk("R8 last byte data", 32'(rd_data), 32'h0001);
    do_read(16'(BASE + TLEN), 1'b1, 16'h3C5A);
    chk("R8 past end data", 32'(rd_data), 32'h3C5A);
    chk("R8 past end hit", 32'(rd_hit), 0);
    do_read(16'hFFFF, 1'b1, 16'h1234);
    chk("R8 top address data", 32'(rd_data), 32'h1234);
  endtask

  task automatic t_mode_off();
    do_read(16'(BASE), 1'b0, 16'hBEEF);
    chk("R9 mode off data", 32'(rd_data), 32'hBEEF);
    chk("R9 mode off hit", 32'(rd_hit), 0);
    chk("R2 mode off valid", 32'(rd_valid), 1);
    do_read(16'(BASE + 30), 1'b0, 16'h0F0F);
    chk("R9 mode off region", 32'(rd_data), 32'h0F0F);
  endtask

  initial begin
    build_model();
    t_reset();
    t_signature();
    t_header();
    t_regions();
    t_edges();
    t_mode_off();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule